// File: doc/BRIEF.md
# Multi-Lane Converter Frame Deserializer

This block sits behind an eight-channel, simultaneous-sampling analog-to-digital converter. The converter ships every conversion result as a 24-bit serial frame on one or more data lanes. A strobe marks the first bit of a frame. The block shifts in one bit per lane on every clock and locks to the frame boundary on the strobe. It works out which channel each frame belongs to from the selected lane arrangement. Each frame is split into an 8-bit status header and a 16-bit two's-complement sample.

Finished samples go into an eight-entry queue, tagged with their channel number. A consumer on the host side reads the queue through a valid/ready port. Frames run back to back with no idle cycles, so capture never pauses.

If a strobe arrives in the middle of a frame, the block resynchronises and counts the event. A full queue drops new samples and raises a sticky flag, which software clears with a pulse.

Top module: `adc_lane_deser`

## Requirements
- R1: After reset, `out_valid`, `overflow` and `sync_err_cnt` are all zero.
- R2: Until the first `frame_start` after reset, lane activity is ignored and nothing is queued.
- R3: Bits arrive MSB first. The first 8 bits of a frame form `out_hdr` and the last 16 bits form `out_smp`. Each entry also carries a 3-bit `out_chan`.
- R4: With `lane_mode` = 0 (single lane), only lane 0 is used. Successive frames after a strobe are channels 0, 1, … 7, and the count then wraps to 0.
- R5: With `lane_mode` = 1 (dual lane), lane 0 carries channels 0–3 and lane 1 carries channels 4–7, with the slot advancing per frame and wrapping after 4. Each frame period queues channel k and then channel k+4.
- R6: With `lane_mode` = 2 or 3 (wide), lane n carries channel n. Each frame period queues all eight channels in ascending channel order.
- R7: Once locked, frames are captured back to back. The bit after the last bit of a frame is taken as the first bit of the next frame, with or without a strobe.
- R8: A strobe that arrives when the bit count is not at a frame boundary does three things. It discards the partial frame and increments `sync_err_cnt`, which saturates at its maximum. It also restarts the bit count and channel slot from the strobe bit. A strobe that arrives exactly on a boundary is not an error.
- R9: The queue holds 8 entries and delivers them in arrival order. An entry is removed when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output entry stays unchanged.
- R10: A sample that arrives when the queue is full and nothing is read that cycle is dropped and sets `overflow`. `overflow` stays set until a `clr_ovf` pulse. If a drop and a clear happen in the same cycle, the flag ends up set.
- R11: When the queue is full and the consumer reads in the same cycle that a new sample arrives, the new sample is accepted and nothing is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter data clock; one bit is captured per lane on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_mode | input | 2 | 0 = single lane, 1 = dual lane, 2 or 3 = one lane per channel |
| frame_start | input | 1 | High on the cycle carrying the first bit of a frame |
| lanes_in | input | 8 | Serial data lanes, bit n is lane n |
| out_ready | input | 1 | Consumer accepts the current entry |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Queue holds an entry |
| out_chan | output | 3 | Channel number of the current entry |
| out_hdr | output | 8 | Status header of the current entry |
| out_smp | output | 16 | Two's-complement sample of the current entry |
| overflow | output | 1 | Sticky flag: a sample was dropped |
| sync_err_cnt | output | 8 | Saturating count of mid-frame strobes |

## Verification
The two functions that can meet in a single cycle are the queue accepting a new sample and the consumer removing one while the queue is full. The bench fills the queue with one wide-mode frame period while `out_ready` is held low. It then raises `out_ready` on exactly the cycle that the next frame period's first sample reaches the queue. From then on, each write lands on a full queue together with a read. The result is judged by reading all sixteen samples back in order and confirming that `overflow` is still clear. A checker property also flags any drop in a cycle that has both a read and a write on a full queue.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  localparam int CH_W    = 3;
  localparam int HDR_W   = 8;
  localparam int SMP_W   = 16;
  localparam int FRAME_W = HDR_W + SMP_W;
  localparam int NUM_CH  = 1 << CH_W;

  typedef enum logic [1:0] {
    LM_SERIAL   = 2'd0,
    LM_DUAL     = 2'd1,
    LM_WIDE     = 2'd2,
    LM_WIDE_ALT = 2'd3
  } lane_mode_e;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [HDR_W-1:0] hdr;
    logic [SMP_W-1:0] smp;
  } sample_t;
endpackage

// File: rtl/adc_lane_shift.sv
module adc_lane_shift #(
  parameter int LANES = 8,
  parameter int WORD_W = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_en,
  input  logic [LANES-1:0]              lanes_in,
  output logic [LANES-1:0][WORD_W-1:0]  word_o
);
  // Each lane keeps WORD_W-1 earlier bits; the newest bit is taken live
  // so the full word is ready on the cycle its last bit is sampled.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-2:0] sh_q;
    logic [WORD_W-2:0] sh_d;

    always_comb begin
      sh_d = {sh_q[WORD_W-3:0], lanes_in[l]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else if (shift_en) begin
        sh_q <= sh_d;
      end
    end

    assign word_o[l] = {sh_q, lanes_in[l]};
  end
endmodule

// File: rtl/adc_frame_track.sv
module adc_frame_track
  import adc_deser_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  parameter int SLOT_W = CH_W,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lane_mode,
  input  logic              frame_start,
  output logic              shift_en,
  output logic              frame_done,
  output logic [SLOT_W-1:0] slot,
  output logic [ERR_W-1:0]  sync_err_cnt
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] ONE_BIT  = BIT_W'(1);
  localparam logic [ERR_W-1:0] ERR_MAX  = '1;

  logic              armed_q, armed_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_wrap;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              done_c;

  // Slot after a completed frame, per lane arrangement.
  always_comb begin
    case (lane_mode)
      LM_SERIAL: slot_wrap = slot_q + 1'b1;
      LM_DUAL:   slot_wrap = {1'b0, (SLOT_W-1)'(slot_q[SLOT_W-2:0] + 1'b1)};
      default:   slot_wrap = '0;
    endcase
  end

  always_comb begin
    armed_d = armed_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    err_d   = err_q;
    done_c  = 1'b0;
    if (frame_start) begin
      armed_d = 1'b1;
      bit_d   = ONE_BIT;
      slot_d  = '0;
      if (armed_q && (bit_q != '0) && (err_q != ERR_MAX)) begin
        err_d = err_q + 1'b1;
      end
    end else if (armed_q) begin
      if (bit_q == LAST_BIT) begin
        done_c = 1'b1;
        bit_d  = '0;
        slot_d = slot_wrap;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bit_q   <= '0;
      slot_q  <= '0;
      err_q   <= '0;
    end else begin
      armed_q <= armed_d;
      bit_q   <= bit_d;
      slot_q  <= slot_d;
      err_q   <= err_d;
    end
  end

  assign shift_en     = frame_start | armed_q;
  assign frame_done   = done_c;
  assign slot         = slot_q;
  assign sync_err_cnt = err_q;
endmodule

// File: rtl/adc_batch_seq.sv
module adc_batch_seq
  import adc_deser_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    lane_mode,
  input  logic                          frame_done,
  input  logic [CH_W-1:0]               slot,
  input  logic [NUM_CH-1:0][FRAME_W-1:0] words,
  output logic                          wr_req,
  output sample_t                       wr_data
);
  logic [NUM_CH-1:0]              pend_q, pend_d;
  logic [NUM_CH-1:0]              load;
  logic [NUM_CH-1:0][FRAME_W-1:0] src;
  logic [NUM_CH-1:0][FRAME_W-1:0] hold_q;
  logic [NUM_CH-1:0]              sel_mask;
  logic [CH_W-1:0]                sel_idx;
  logic                           found;

  // Hold slot c always belongs to channel c; mode picks which lane feeds it.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    localparam logic [CH_W-1:0] CI = CH_W'(c);
    localparam int DUAL_SRC = c >> (CH_W - 1);

    always_comb begin
      case (lane_mode)
        LM_SERIAL: begin
          load[c] = frame_done && (slot == CI);
          src[c]  = words[0];
        end
        LM_DUAL: begin
          load[c] = frame_done && (slot[CH_W-2:0] == CI[CH_W-2:0]);
          src[c]  = words[DUAL_SRC];
        end
        default: begin
          load[c] = frame_done;
          src[c]  = words[c];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[c] <= '0;
      end else if (load[c]) begin
        hold_q[c] <= src[c];
      end
    end
  end

  // Lowest pending channel goes out first: ascending order.
  always_comb begin
    sel_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_q[i] && !found) begin
        found   = 1'b1;
        sel_idx = CH_W'(i);
      end
    end
    sel_mask = found ? (NUM_CH'(1) << sel_idx) : '0;
    pend_d   = (pend_q & ~sel_mask) | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign wr_req       = found;
  assign wr_data.chan = sel_idx;
  assign wr_data.hdr  = hold_q[sel_idx][FRAME_W-1 -: HDR_W];
  assign wr_data.smp  = hold_q[sel_idx][SMP_W-1:0];
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_deser_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  sample_t                     wr_data,
  input  logic                        rd_ready,
  output logic                        rd_valid,
  output sample_t                     rd_data,
  output logic                        drop,
  output logic                        full,
  output logic [$clog2(DEPTH+1)-1:0]  cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  sample_t           mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              push, pop;

  always_comb begin
    pop  = (cnt_q != '0) && rd_ready;
    push = wr_req && ((cnt_q != CNT_FULL) || pop);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_valid = (cnt_q != '0);
  assign rd_data  = mem[rd_ptr_q];
  assign drop     = wr_req && !push;
  assign full     = (cnt_q == CNT_FULL);
  assign cnt      = cnt_q;
endmodule

// File: rtl/adc_lane_deser.sv
module adc_lane_deser
  import adc_deser_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        lane_mode,
  input  logic              frame_start,
  input  logic [NUM_CH-1:0] lanes_in,
  input  logic              out_ready,
  input  logic              clr_ovf,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [HDR_W-1:0]  out_hdr,
  output logic [SMP_W-1:0]  out_smp,
  output logic              overflow,
  output logic [ERR_W-1:0]  sync_err_cnt
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                           shift_en, frame_done;
  logic [CH_W-1:0]                slot;
  logic [NUM_CH-1:0][FRAME_W-1:0] words;
  logic                           wr_req;
  sample_t                        wr_data, rd_data;
  logic                           fifo_drop, fifo_full;
  logic [CNT_W-1:0]               fifo_cnt;
  logic                           ovf_q, ovf_d;

  adc_frame_track #(.FRAME_BITS(FRAME_W), .SLOT_W(CH_W), .ERR_W(ERR_W)) u_track (
    .clk(clk), .rst_n(rst_core_n), .lane_mode(lane_mode),
    .frame_start(frame_start), .shift_en(shift_en), .frame_done(frame_done),
    .slot(slot), .sync_err_cnt(sync_err_cnt)
  );

  adc_lane_shift #(.LANES(NUM_CH), .WORD_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .shift_en(shift_en),
    .lanes_in(lanes_in), .word_o(words)
  );

  adc_batch_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .lane_mode(lane_mode),
    .frame_done(frame_done), .slot(slot), .words(words),
    .wr_req(wr_req), .wr_data(wr_data)
  );

  adc_sample_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .wr_req(wr_req), .wr_data(wr_data),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(rd_data),
    .drop(fifo_drop), .full(fifo_full), .cnt(fifo_cnt)
  );

  // A drop in the same cycle as a clear leaves the flag set.
  always_comb begin
    ovf_d = ovf_q;
    if (clr_ovf)   ovf_d = 1'b0;
    if (fifo_drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ovf_q <= 1'b0;
    else             ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;
  assign out_chan = rd_data.chan;
  assign out_hdr  = rd_data.hdr;
  assign out_smp  = rd_data.smp;
endmodule

// File: rtl/adc_lane_deser_chk.sv
module adc_lane_deser_chk #(
  parameter int ENTRY_W = 27,
  parameter int ERR_W = 8,
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ENTRY_W-1:0] out_entry,
  input logic               overflow,
  input logic               clr_ovf,
  input logic [ERR_W-1:0]   sync_err_cnt,
  input logic [CNT_W-1:0]   fifo_cnt,
  input logic               fifo_full,
  input logic               wr_req,
  input logic               fifo_drop
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen_q <= 1'b0;
    else if (frame_start) seen_q <= 1'b1;
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !out_valid);

  a_r8_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_err_cnt == $past(sync_err_cnt)) ||
             (sync_err_cnt == $past(sync_err_cnt) + 1'b1));

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err_cnt != $past(sync_err_cnt)) |-> $past(frame_start));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));

  a_r9_depth: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> overflow);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !fifo_drop) |=> !overflow);

  a_r11_full_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && out_ready && wr_req) |-> !fifo_drop);
endmodule

bind adc_lane_deser adc_lane_deser_chk #(
  .ENTRY_W(adc_deser_pkg::CH_W + adc_deser_pkg::FRAME_W),
  .ERR_W(ERR_W),
  .CNT_W($clog2(FIFO_DEPTH + 1)),
  .DEPTH(FIFO_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_entry({out_chan, out_hdr, out_smp}),
  .overflow(overflow), .clr_ovf(clr_ovf), .sync_err_cnt(sync_err_cnt),
  .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .wr_req(wr_req),
  .fifo_drop(fifo_drop)
);

// File: tb/adc_lane_deser_tb.sv
`timescale 1ns/1ps
module adc_lane_deser_tb_top;
  import adc_deser_pkg::*;

  logic              clk;
  logic              rst_n;
  logic [1:0]        lane_mode;
  logic              frame_start;
  logic [NUM_CH-1:0] lanes_in;
  logic              out_ready;
  logic              clr_ovf;
  logic              out_valid;
  logic [CH_W-1:0]   out_chan;
  logic [HDR_W-1:0]  out_hdr;
  logic [SMP_W-1:0]  out_smp;
  logic              overflow;
  logic [7:0]        sync_err_cnt;

  adc_lane_deser dut_i (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .frame_start(frame_start),
    .lanes_in(lanes_in), .out_ready(out_ready), .clr_ovf(clr_ovf),
    .out_valid(out_valid), .out_chan(out_chan), .out_hdr(out_hdr),
    .out_smp(out_smp), .overflow(overflow), .sync_err_cnt(sync_err_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done_flag = 0;
  bit    mon_en = 0;
  string mon_req = "";
  logic [26:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // Output monitor: compares each accepted entry with the expected stream.
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, mon_req, 32'({out_chan, out_hdr, out_smp}), 32'h0);
      end else begin
        chk({out_chan, out_hdr, out_smp} == exp_q[0], mon_req,
            32'({out_chan, out_hdr, out_smp}), 32'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  function automatic logic [23:0] word_of(input int lane, input int f, input int seed);
    logic [7:0]  h;
    logic [15:0] s;
    h = 8'((lane << 5) ^ f ^ seed);
    s = 16'(seed * 977 + lane * 4099 + f * 311 + 32'h8001);
    return {h, s};
  endfunction

  task automatic tick(input bit fs, input logic [NUM_CH-1:0] ln);
    @(posedge clk);
    #1;
    frame_start = fs;
    lanes_in = ln;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0;
    lane_mode = m;
    frame_start = 1'b0;
    lanes_in = '0;
    out_ready = 1'b0;
    clr_ovf = 1'b0;
    mon_en = 0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
  endtask

  // Streams nfr frames back to back; strobe on the first bit only.
  // The last frame is cut to 'cut' bits. Full frames add expected entries.
  task automatic send(input int m, input int nfr, input int cut, input int seed);
    for (int f = 0; f < nfr; f++) begin
      int nb;
      nb = (f == nfr - 1) ? cut : 24;
      for (int b = 0; b < nb; b++) begin
        logic [NUM_CH-1:0] ln;
        for (int l = 0; l < NUM_CH; l++) begin
          logic [23:0] w;
          w = word_of(l, f, seed);
          ln[l] = w[23 - b];
        end
        tick((b == 0) && (f == 0), ln);
      end
      if (nb == 24) begin
        if (m == 0) begin
          exp_q.push_back({3'(f % 8), word_of(0, f, seed)});
        end else if (m == 1) begin
          exp_q.push_back({3'(f % 4), word_of(0, f, seed)});
          exp_q.push_back({3'(f % 4 + 4), word_of(1, f, seed)});
        end else begin
          for (int l = 0; l < NUM_CH; l++) exp_q.push_back({3'(l), word_of(l, f, seed)});
        end
      end
    end
  endtask

  task automatic t_reset;
    do_reset(2'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 0);
    chk(sync_err_cnt == 8'd0, "R1 sync_err_cnt", 32'(sync_err_cnt), 0);
  endtask

  task automatic t_idle;
    do_reset(2'd0);
    for (int i = 0; i < 80; i++) tick(1'b0, 8'(i * 37 + 5));
    idle(2);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 no entry before strobe", 32'(out_valid), 0);
    chk(sync_err_cnt == 8'd0, "R2 no error before strobe", 32'(sync_err_cnt), 0);
  endtask

  task automatic t_mode(input int m, input logic [1:0] code, input int nfr,
                        input int seed, input string req);
    do_reset(code);
    out_ready = 1'b1;
    mon_req = req;
    mon_en = 1;
    send(m, nfr, 24, seed);
    idle(12);
    @(negedge clk);
    mon_en = 0;
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 0);
  endtask

  task automatic t_resync;
    do_reset(2'd0);
    out_ready = 1'b1;
    mon_req = "R8 resync stream";
    mon_en = 1;
    send(0, 2, 10, 21);
    send(0, 2, 24, 77);
    send(0, 1, 24, 90);
    idle(12);
    @(negedge clk);
    mon_en = 0;
    chk(exp_q.size() == 0, "R8 entries after resync", 32'(exp_q.size()), 0);
    chk(sync_err_cnt == 8'd1, "R8 one sync error only", 32'(sync_err_cnt), 1);
  endtask

  task automatic t_overflow;
    do_reset(2'd2);
    mon_req = "R9 order after overflow";
    mon_en = 1;
    send(2, 2, 24, 44);
    for (int i = 0; i < 8; i++) void'(exp_q.pop_back());
    idle(10);
    @(negedge clk);
    chk(overflow == 1'b1, "R10 overflow set", 32'(overflow), 1);
    chk(out_valid && out_chan == 3'd0, "R9 head held while not ready",
        32'(out_chan), 0);
    @(posedge clk);
    #1 out_ready = 1'b1;
    idle(9);
    @(negedge clk);
    mon_en = 0;
    chk(exp_q.size() == 0, "R9 eight kept in order", 32'(exp_q.size()), 0);
    chk(overflow == 1'b1, "R10 overflow sticky", 32'(overflow), 1);
    @(posedge clk);
    #1 clr_ovf = 1'b1;
    @(posedge clk);
    #1 clr_ovf = 1'b0;
    @(negedge clk);
    chk(overflow == 1'b0, "R10 overflow cleared", 32'(overflow), 0);
  endtask

  task automatic t_full_pop;
    do_reset(2'd2);
    mon_req = "R11 write with pop on full";
    mon_en = 1;
    send(2, 2, 24, 63);
    @(posedge clk);
    #1 out_ready = 1'b1;
    idle(16);
    @(negedge clk);
    mon_en = 0;
    chk(exp_q.size() == 0, "R11 all sixteen delivered", 32'(exp_q.size()), 0);
    chk(overflow == 1'b0, "R11 no overflow", 32'(overflow), 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_mode(0, 2'd0, 10, 5, "R3 R4 R7 single lane");
    t_mode(1, 2'd1, 6, 17, "R5 dual lane");
    t_mode(2, 2'd2, 3, 33, "R6 R7 wide lane");
    t_mode(2, 2'd3, 1, 51, "R6 wide alt code");
    t_resync();
    t_overflow();
    t_full_pop();
    finish_run();
  end
endmodule